// File: doc/BRIEF.md
# Runtime-Programmable Logic Plane

This block is one plane of a programmable logic array whose function is held in a small writable personality store rather than fixed in gates. It takes a vector of input terms and produces a vector of output terms. Each output is computed from its own personality row. That row decides, for every input, whether the input takes part in the term and in which polarity. The partial terms are then combined with a selectable function: AND, OR, NAND or NOR.

Rows are written one at a time through a simple write port and can be rewritten at any point in operation. Two row formats are offered. The mask format only marks inputs as included or excluded. The literal format picks the true input, the complemented input, or a don't-care for each position. A build-time parameter selects how the outputs update. In the combinational variant they follow inputs and row writes directly. In the strobed variant they are captured into a register on a clock edge while the evaluate strobe is high.

Top module: `pla_logic_plane`

## Requirements
- R1: Row address r (0-based) alone determines output term r+1, which is out_terms bit M_OUT-1-r. Writing one row leaves every other output term unchanged.
- R2: Input term 1 is in_terms bit N_IN-1 (the MSB). Input term j is encoded in row bits [2(N_IN-j)+1 : 2(N_IN-j)], so the leftmost position of a row belongs to input 1.
- R3: With fmt_sel=0 (mask format), the low bit of a position set to 1 includes that input uncomplemented, and 0 excludes it. The high bit of the position has no effect.
- R4: With fmt_sel=1 (literal format), position code 00 uses the complemented input, 01 uses the true input, and 10 or 11 makes the input a don't-care.
- R5: fn_sel selects the combining function: 0 AND, 1 OR, 2 NAND, 3 NOR. The same choice applies in both formats. NAND and NOR are the inversions of the AND and OR results.
- R6: Excluded and don't-care positions contribute the identity of the combining function. A row with no contributing position therefore yields 1 under AND, 0 under OR, 0 under NAND and 1 under NOR.
- R7: With SYNC_EVAL=0, the outputs follow in_terms, fmt_sel and fn_sel combinationally. A row write is visible on the outputs right after the clock edge that stores it.
- R8: With SYNC_EVAL=1, the outputs change only at a rising clock edge where eval_strb is 1, and they hold at every other time. A row write therefore appears at the next such evaluation.
- R9: Reset clears every personality position to 00 and clears the strobed output register to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for personality writes and strobed evaluation |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_terms | input | N_IN | Input term vector, MSB is input 1 |
| fmt_sel | input | 1 | Row format: 0 mask, 1 literal |
| fn_sel | input | 2 | Combining function: 0 AND, 1 OR, 2 NAND, 3 NOR |
| eval_strb | input | 1 | Evaluate strobe (strobed variant only) |
| wr_en | input | 1 | Personality row write enable |
| wr_row | input | max(1,clog2(M_OUT)) | Row address, 0 drives output 1 |
| wr_data | input | 2*N_IN | Row contents, two bits per input position |
| out_terms | output | M_OUT | Output term vector, MSB is output 1 |

## Verification
Two personalities are loaded: a sparse include mask over seven inputs and a three-input literal set padded with don't-cares. Each is run through all four combining functions. Single-hot and clustered input patterns show whether positions map to the right inputs and rows to the right outputs. All-zero and all-one vectors separate the AND/OR identities from their inverted forms. Directed writes of codes 11 and 10 show whether the mask format ignores the high bit. A second instance with strobed evaluation is driven with the strobe low across input changes and row writes, which separates holding from updating.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'd0,
    FN_OR   = 2'd1,
    FN_NAND = 2'd2,
    FN_NOR  = 2'd3
  } pla_fn_e;

  typedef enum logic {
    FMT_MASK    = 1'b0,
    FMT_LITERAL = 1'b1
  } pla_fmt_e;

  // position code bits within a two-bit literal slot
  localparam int unsigned POS_W     = 2;
  localparam int unsigned POS_POL   = 0;  // polarity / include bit
  localparam int unsigned POS_DCARE = 1;  // don't-care bit (literal format)

endpackage

// File: rtl/pla_pers_mem.sv
module pla_pers_mem
  import pla_pkg::*;
#(
  parameter int unsigned N_IN  = 7,
  parameter int unsigned M_OUT = 4,
  localparam int unsigned ROW_W = N_IN * POS_W,
  localparam int unsigned RW    = (M_OUT > 1) ? $clog2(M_OUT) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [RW-1:0]                    wr_row,
  input  logic [ROW_W-1:0]                 wr_data,
  output logic [M_OUT-1:0][ROW_W-1:0]      rows_o
);

  logic [M_OUT-1:0][ROW_W-1:0] rows_d;
  logic [M_OUT-1:0][ROW_W-1:0] rows_q;
  logic [M_OUT-1:0]            row_sel;

  // row decode, one select per stored row
  for (genvar r = 0; r < M_OUT; r++) begin : g_sel
    assign row_sel[r] = wr_en && (wr_row == RW'(r));
  end

  always_comb begin
    rows_d = rows_q;
    for (int r = 0; r < M_OUT; r++) begin
      if (row_sel[r]) rows_d[r] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= '0;
    end else if (wr_en) begin
      rows_q <= rows_d;
    end
  end

  assign rows_o = rows_q;

  for (genvar r = 0; r < M_OUT; r++) begin : g_chk
    p_row_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_row == RW'(r)) |=> (rows_q[r] == $past(wr_data)));
    p_row_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_row == RW'(r)) |=> $stable(rows_q[r]));
  end

endmodule

// File: rtl/pla_row_eval.sv
module pla_row_eval
  import pla_pkg::*;
#(
  parameter int unsigned N_IN = 7,
  localparam int unsigned ROW_W = N_IN * POS_W
) (
  input  logic [ROW_W-1:0] row_bits,
  input  logic [N_IN-1:0]  in_terms,
  input  pla_fmt_e         fmt,
  input  pla_fn_e          fn,
  output logic             term_o
);

  logic [N_IN-1:0] use_pos;   // position contributes to the term
  logic [N_IN-1:0] lit_val;   // literal value seen by the combiner
  logic            and_acc;
  logic            or_acc;

  // per-position decode: bit p of in_terms pairs with row slot p
  for (genvar p = 0; p < N_IN; p++) begin : g_pos
    logic [POS_W-1:0] code;
    assign code = row_bits[POS_W*p +: POS_W];

    always_comb begin
      if (fmt == FMT_MASK) begin
        use_pos[p] = code[POS_POL];
        lit_val[p] = in_terms[p];
      end else begin
        use_pos[p] = ~code[POS_DCARE];
        lit_val[p] = code[POS_POL] ? in_terms[p] : ~in_terms[p];
      end
    end
  end

  // excluded positions are forced to the combiner identity
  always_comb begin
    and_acc = &(lit_val | ~use_pos);
    or_acc  = |(lit_val & use_pos);
    unique case (fn)
      FN_AND:  term_o = and_acc;
      FN_OR:   term_o = or_acc;
      FN_NAND: term_o = ~and_acc;
      FN_NOR:  term_o = ~or_acc;
      default: term_o = and_acc;
    endcase
  end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int unsigned M_OUT     = 4,
  parameter bit          SYNC_EVAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_strb,
  input  logic [M_OUT-1:0] terms_i,
  output logic [M_OUT-1:0] terms_o
);

  if (SYNC_EVAL) begin : g_sync
    logic [M_OUT-1:0] terms_d;
    logic [M_OUT-1:0] terms_q;

    always_comb begin
      terms_d = terms_q;
      if (eval_strb) terms_d = terms_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        terms_q <= '0;
      end else if (eval_strb) begin
        terms_q <= terms_d;
      end
    end

    assign terms_o = terms_q;

    p_eval_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_strb |=> $stable(terms_o));
    p_eval_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eval_strb |=> (terms_o == $past(terms_i)));
  end else begin : g_async
    logic stage_unused;
    assign stage_unused = ^{clk, rst_n, eval_strb};
    assign terms_o = terms_i;
  end

endmodule

// File: rtl/pla_logic_plane.sv
module pla_logic_plane
  import pla_pkg::*;
#(
  parameter int unsigned N_IN      = 7,
  parameter int unsigned M_OUT     = 4,
  parameter bit          SYNC_EVAL = 1'b0,
  localparam int unsigned ROW_W = N_IN * POS_W,
  localparam int unsigned RW    = (M_OUT > 1) ? $clog2(M_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_terms,
  input  logic              fmt_sel,
  input  logic [1:0]        fn_sel,
  input  logic              eval_strb,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_row,
  input  logic [ROW_W-1:0]  wr_data,
  output logic [M_OUT-1:0]  out_terms
);

  localparam logic [ROW_W-1:0] POL_MASK = {N_IN{2'b01}};

  pla_fmt_e                    fmt;
  pla_fn_e                     fn;
  logic [M_OUT-1:0][ROW_W-1:0] rows;
  logic [M_OUT-1:0]            terms_comb;

  assign fmt = pla_fmt_e'(fmt_sel);
  assign fn  = pla_fn_e'(fn_sel);

  pla_pers_mem #(
    .N_IN  (N_IN),
    .M_OUT (M_OUT)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_data (wr_data),
    .rows_o  (rows)
  );

  // row r (address) feeds output r+1, i.e. the bit counted from the MSB
  for (genvar r = 0; r < M_OUT; r++) begin : g_row
    pla_row_eval #(
      .N_IN (N_IN)
    ) u_eval (
      .row_bits (rows[r]),
      .in_terms (in_terms),
      .fmt      (fmt),
      .fn       (fn),
      .term_o   (terms_comb[M_OUT-1-r])
    );
  end

  pla_out_stage #(
    .M_OUT     (M_OUT),
    .SYNC_EVAL (SYNC_EVAL)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_strb (eval_strb),
    .terms_i   (terms_comb),
    .terms_o   (out_terms)
  );

  // an empty mask row under AND must read as constant 1 at the port
  if (!SYNC_EVAL) begin : g_chk
    for (genvar r = 0; r < M_OUT; r++) begin : g_empty
      p_empty_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 1'b0 && fn_sel == 2'd0 && (rows[r] & POL_MASK) == '0)
          |-> out_terms[M_OUT-1-r]);
    end
  end

endmodule

// File: tb/pla_logic_plane_tb.sv
module pla_logic_plane_tb_top;

  localparam int N = 7;
  localparam int M = 4;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] in_terms;
  logic         fmt_sel;
  logic [1:0]   fn_sel;
  logic         eval_strb;
  logic         wr_en;
  logic [1:0]   wr_row;
  logic [W-1:0] wr_data;
  logic [M-1:0] out_a;
  logic [M-1:0] out_s;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  pla_logic_plane #(.N_IN(N), .M_OUT(M), .SYNC_EVAL(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_terms(in_terms), .fmt_sel(fmt_sel),
    .fn_sel(fn_sel), .eval_strb(eval_strb), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .out_terms(out_a));

  pla_logic_plane #(.N_IN(N), .M_OUT(M), .SYNC_EVAL(1'b1)) dut_sync_i (
    .clk(clk), .rst_n(rst_n), .in_terms(in_terms), .fmt_sel(fmt_sel),
    .fn_sel(fn_sel), .eval_strb(eval_strb), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .out_terms(out_s));

  // literal-format rows, input 1 in the leftmost slot (R2, R4)
  localparam logic [W-1:0] LIT_R0 = 14'b01_00_10_10_10_10_10; // a1 & ~a2
  localparam logic [W-1:0] LIT_R1 = 14'b10_10_01_10_10_10_10; // a3
  localparam logic [W-1:0] LIT_R2 = 14'b00_10_00_10_10_10_10; // ~a1 & ~a3
  localparam logic [W-1:0] LIT_R3 = 14'b10_10_10_10_10_10_10; // all don't-care

  // {set, fmt, fn, in, expected}
  localparam int NV = 22;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 7'b1111111, 4'b1111},
    {1'b0, 1'b0, 2'd0, 7'b0000000, 4'b0001},
    {1'b0, 1'b0, 2'd0, 7'b1100000, 4'b1001},
    {1'b0, 1'b0, 2'd0, 7'b0011100, 4'b0101},
    {1'b0, 1'b0, 2'd0, 7'b0000111, 4'b0011},
    {1'b0, 1'b0, 2'd0, 7'b0010111, 4'b0011},
    {1'b0, 1'b0, 2'd1, 7'b0000000, 4'b0000},
    {1'b0, 1'b0, 2'd1, 7'b1000000, 4'b1000},
    {1'b0, 1'b0, 2'd1, 7'b0000100, 4'b0110},
    {1'b0, 1'b0, 2'd1, 7'b0000001, 4'b0010},
    {1'b0, 1'b0, 2'd2, 7'b1100000, 4'b0110},
    {1'b0, 1'b0, 2'd2, 7'b1111111, 4'b0000},
    {1'b0, 1'b0, 2'd3, 7'b0000000, 4'b1111},
    {1'b0, 1'b0, 2'd3, 7'b0010000, 4'b1011},
    {1'b1, 1'b1, 2'd0, 7'b1110110, 4'b0101},
    {1'b1, 1'b1, 2'd0, 7'b0001011, 4'b0011},
    {1'b1, 1'b1, 2'd0, 7'b1011010, 4'b1101},
    {1'b1, 1'b1, 2'd0, 7'b1000000, 4'b1001},
    {1'b1, 1'b1, 2'd1, 7'b1110000, 4'b1100},
    {1'b1, 1'b1, 2'd1, 7'b0101111, 4'b0010},
    {1'b1, 1'b1, 2'd2, 7'b1010000, 4'b0010},
    {1'b1, 1'b1, 2'd3, 7'b0100000, 4'b1101}
  };

  function automatic logic [W-1:0] mask_row(input logic [N-1:0] m);
    logic [W-1:0] r;
    r = '0;
    for (int p = 0; p < N; p++) r[2*p] = m[p];
    return r;
  endfunction

  task automatic check(input string tag, input logic [M-1:0] act,
                       input logic [M-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns after the next falling edge
  task automatic write_row(input logic [1:0] r, input logic [W-1:0] d);
    wr_en = 1'b1; wr_row = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_set(input logic s);
    if (!s) begin
      write_row(2'd0, mask_row(7'b1100000));
      write_row(2'd1, mask_row(7'b0011100));
      write_row(2'd2, mask_row(7'b0000111));
      write_row(2'd3, mask_row(7'b0000000));
    end else begin
      write_row(2'd0, LIT_R0);
      write_row(2'd1, LIT_R1);
      write_row(2'd2, LIT_R2);
      write_row(2'd3, LIT_R3);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_terms = '0; fmt_sel = 1'b0; fn_sel = 2'd0;
    eval_strb = 1'b0; wr_en = 1'b0; wr_row = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: cleared rows read as empty masks / all-complement literals
    in_terms = 7'b1010101; #2;
    check("R9 reset mask AND", out_a, 4'b1111);
    check("R9 reset strobed register", out_s, 4'b0000);
    fn_sel = 2'd1; #1;
    check("R9 reset mask OR (R6)", out_a, 4'b0000);
    fmt_sel = 1'b1; fn_sel = 2'd0; in_terms = 7'b0000000; #1;
    check("R9 reset literal complement", out_a, 4'b1111);
    in_terms = 7'b0000001; #1;
    check("R9 reset literal one input high", out_a, 4'b0000);
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R6, async and strobed paths
    eval_strb = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || VEC[i][14] != VEC[i-1][14]) load_set(VEC[i][14]);
      fmt_sel  = VEC[i][13];
      fn_sel   = VEC[i][12:11];
      in_terms = VEC[i][10:4];
      #2;
      check($sformatf("R2/R3/R4/R5 vector %0d async", i), out_a, VEC[i][3:0]);
      @(negedge clk);
      check($sformatf("R8 vector %0d strobed", i), out_s, VEC[i][3:0]);
    end

    // R8 hold and R7 immediate write visibility
    eval_strb = 1'b0; fmt_sel = 1'b0; fn_sel = 2'd0;
    load_set(1'b0);
    in_terms = 7'b1111111; eval_strb = 1'b1;
    @(negedge clk);
    check("R8 strobed load", out_s, 4'b1111);
    eval_strb = 1'b0; in_terms = 7'b1100000;
    @(negedge clk);
    check("R8 hold with strobe low", out_s, 4'b1111);
    check("R7 async follows input", out_a, 4'b1001);
    write_row(2'd0, mask_row(7'b1111111));
    check("R7 write visible after edge, R1 other rows kept", out_a, 4'b0001);
    check("R8 write not seen before evaluation", out_s, 4'b1111);
    eval_strb = 1'b1;
    @(negedge clk);
    check("R8 write seen at evaluation", out_s, 4'b0001);
    eval_strb = 1'b0;

    // R3: high bit ignored in mask format
    write_row(2'd3, {N{2'b11}});
    in_terms = 7'b1111111; #1;
    check("R3 code 11 includes", out_a, 4'b1111);
    in_terms = 7'b1111110; #1;
    check("R3 code 11 uses true input", out_a, 4'b0100);
    @(negedge clk);
    write_row(2'd3, {N{2'b10}});
    fn_sel = 2'd1; in_terms = 7'b1111111; #1;
    check("R3 code 10 excludes under OR (R6)", out_a, 4'b1110);

    // R4: code 11 is a don't-care in literal format
    @(negedge clk);
    write_row(2'd3, {N{2'b11}});
    fmt_sel = 1'b1; fn_sel = 2'd0; in_terms = 7'b0000000; #1;
    check("R4 code 11 don't-care", out_a, 4'b0001);
    fn_sel = 2'd3; #1;
    check("R6 empty literal row under NOR", out_a[0], 1'b1);

    @(negedge clk);
    finish_run();
  end

endmodule